// File: doc/BRIEF.md
# Acknowledgement Wait Timer with Replay Rollover Detect

This block sits in the link layer of a serial packet link, beside the retransmit logic. It measures how long transmitted packets have gone without acknowledgement. A programmable limit sets how long the timer may run. When the limit runs out, the block emits a one-cycle timeout pulse and the timer starts again by itself. The timer starts when a packet transmission begins or ends while the timer is idle. It starts again from zero whenever a received control packet (ACK/NAK) arrives while unacknowledged packets are still held. It stops and clears once nothing remains unacknowledged.

Next to the timer, a small replay-attempt counter advances on each replay event. It clears when an acknowledgement shows forward progress. When the counter steps from its top value of three to the fourth attempt, it wraps to zero and emits a one-cycle rollover pulse. The surrounding logic uses this pulse to escalate, for example by retraining the link.

Top module: `replay_watch`

## Requirements
- R1: After reset, both pulse outputs are low, the timer is idle and the replay count is zero. With `unackPending` high and no start strobe, no timeout occurs.
- R2: When the timer is idle and `txStart` or `txEnd` is sampled high, the timer restarts from zero. The first `timeoutPulse` comes `timeoutLimit`+1 cycles after that edge. A limit of zero behaves as a limit of one.
- R3: `txStart` or `txEnd` sampled while the timer is running leaves the count undisturbed.
- R4: `dllpRcvd` sampled while the timer runs and `unackPending` is high restarts the count from zero. `dllpRcvd` while the timer is idle does not start it.
- R5: On expiry the timer restarts on its own. While nothing else happens, timeouts repeat every `timeoutLimit`+1 cycles.
- R6: When `unackPending` is low and no start strobe is present, the timer stops and clears, and no timeout follows.
- R7: `timeoutPulse` is high for exactly one cycle per expiry.
- R8: Each `replayEvent` advances the replay count. The event that finds the count at three wraps it to zero and raises `rolloverPulse` in the next cycle.
- R9: `replayCntClr` clears the replay count. It takes priority over a `replayEvent` in the same cycle, and no rollover follows it.
- R10: `rolloverPulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Strobe: first word of a packet being sent |
| txEnd | input | 1 | Strobe: last word of a packet being sent |
| dllpRcvd | input | 1 | Strobe: an ACK/NAK control packet arrived |
| unackPending | input | 1 | Level: retry storage holds unacknowledged packets |
| replayEvent | input | 1 | Strobe: a replay of stored packets begins |
| replayCntClr | input | 1 | Strobe: acknowledgement made forward progress |
| timeoutLimit | input | CNT_W | Timer expiry limit in cycles |
| timeoutPulse | output | 1 | One-cycle pulse on timer expiry |
| rolloverPulse | output | 1 | One-cycle pulse when replay count goes from three to four |

## Verification
On every cycle, the assertions check that both outputs are single-cycle pulses and that a timeout only ever follows a cycle with unacknowledged packets pending. They also check that a rollover always traces back to an uncleared replay event, and that a clear strobe suppresses the next rollover. The exact timing of expiry, in particular its distance from a start, a DLLP restart or an ignored start strobe, and the automatic repeat period, can only be shown by the bench. The bench sweeps small limits and strobe offsets for this. The replay-count arithmetic across long event and clear patterns is likewise covered by the bench's cycle-by-cycle model.

// File: rtl/replay_watch_pkg.sv
package replay_watch_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic timerZero;  // load zero into the wait timer
    logic timerStep;  // advance the wait timer by one
    logic rplyClr;    // clear replay attempt count
    logic rplyStep;   // advance replay attempt count
  } dpCmd_t;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmrState_t;

endpackage

// File: rtl/replay_watch_dp.sv
module replay_watch_dp
  import replay_watch_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RPLY_MAX = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] timeoutLimit,
  output logic             atLimit,
  output logic             rplyAtMax
);

  localparam int RPLY_W = (RPLY_MAX < 1) ? 1 : $clog2(RPLY_MAX + 1);
  localparam logic [RPLY_W-1:0] RPLY_TOP = RPLY_W'(RPLY_MAX);
  localparam logic [CNT_W-1:0]  LIMIT_FLOOR = CNT_W'(1);

  logic [CNT_W-1:0]  waitCnt;
  logic [CNT_W-1:0]  effLimit;
  logic [RPLY_W-1:0] rplyCnt;

  // R2: zero limit treated as one so expiry pulses stay separated
  assign effLimit = (timeoutLimit == '0) ? LIMIT_FLOOR : timeoutLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (cmd.timerZero) begin
      waitCnt <= '0;
    end else if (cmd.timerStep) begin
      waitCnt <= waitCnt + CNT_W'(1);
    end
  end

  // Greater-or-equal guards against the limit being lowered mid-count
  assign atLimit = (waitCnt >= effLimit);

  // R8 R9: replay attempt counter, wraps after its top value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rplyCnt <= '0;
    end else if (cmd.rplyClr) begin
      rplyCnt <= '0;
    end else if (cmd.rplyStep) begin
      if (rplyCnt == RPLY_TOP) begin
        rplyCnt <= '0;
      end else begin
        rplyCnt <= rplyCnt + RPLY_W'(1);
      end
    end
  end

  assign rplyAtMax = (rplyCnt == RPLY_TOP);

endmodule

// File: rtl/replay_watch_ctrl.sv
module replay_watch_ctrl
  import replay_watch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txStart,
  input  logic   txEnd,
  input  logic   dllpRcvd,
  input  logic   unackPending,
  input  logic   replayEvent,
  input  logic   replayCntClr,
  input  logic   atLimit,
  input  logic   rplyAtMax,
  output dpCmd_t cmd,
  output logic   timeoutPulse,
  output logic   rolloverPulse
);

  tmrState_t state, stateNext;
  logic      running;
  logic      startReq;
  logic      stopReq;
  logic      expire;
  logic      ackRestart;
  logic      timeoutNext;
  logic      rollNext;

  assign running    = (state == TMR_RUN);
  // R2 R3: a transmit strobe only starts an idle timer
  assign startReq   = (txStart | txEnd) & ~running;
  // R6: nothing outstanding and no start pending
  assign stopReq    = ~unackPending & ~startReq;
  // R5: expiry reloads and keeps running
  assign expire     = running & atLimit;
  // R4: received control packet with packets still outstanding
  assign ackRestart = running & dllpRcvd & unackPending;

  always_comb begin
    cmd           = '0;
    stateNext     = state;
    timeoutNext   = 1'b0;
    if (stopReq) begin
      cmd.timerZero = 1'b1;
      stateNext     = TMR_IDLE;
    end else if (expire) begin
      cmd.timerZero = 1'b1;
      stateNext     = TMR_RUN;
      timeoutNext   = 1'b1;
    end else if (ackRestart || startReq) begin
      cmd.timerZero = 1'b1;
      stateNext     = TMR_RUN;
    end else if (running) begin
      cmd.timerStep = 1'b1;
    end

    // R9: clear wins over a same-cycle replay event
    cmd.rplyClr  = replayCntClr;
    cmd.rplyStep = replayEvent & ~replayCntClr;
  end

  // R8: rollover when the event finds the count at its top value
  assign rollNext = replayEvent & ~replayCntClr & rplyAtMax;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= TMR_IDLE;
      timeoutPulse  <= 1'b0;
      rolloverPulse <= 1'b0;
    end else begin
      state         <= stateNext;
      timeoutPulse  <= timeoutNext;
      rolloverPulse <= rollNext;
    end
  end

endmodule

// File: rtl/replay_watch.sv
module replay_watch
  import replay_watch_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RPLY_MAX = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic             txEnd,
  input  logic             dllpRcvd,
  input  logic             unackPending,
  input  logic             replayEvent,
  input  logic             replayCntClr,
  input  logic [CNT_W-1:0] timeoutLimit,
  output logic             timeoutPulse,
  output logic             rolloverPulse
);

  dpCmd_t dpCmd;
  logic   atLimit;
  logic   rplyAtMax;

  replay_watch_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .txStart       (txStart),
    .txEnd         (txEnd),
    .dllpRcvd      (dllpRcvd),
    .unackPending  (unackPending),
    .replayEvent   (replayEvent),
    .replayCntClr  (replayCntClr),
    .atLimit       (atLimit),
    .rplyAtMax     (rplyAtMax),
    .cmd           (dpCmd),
    .timeoutPulse  (timeoutPulse),
    .rolloverPulse (rolloverPulse)
  );

  replay_watch_dp #(
    .CNT_W    (CNT_W),
    .RPLY_MAX (RPLY_MAX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (dpCmd),
    .timeoutLimit (timeoutLimit),
    .atLimit      (atLimit),
    .rplyAtMax    (rplyAtMax)
  );

endmodule

// File: rtl/replay_watch_chk.sv
module replay_watch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txStart,
  input logic             txEnd,
  input logic             dllpRcvd,
  input logic             unackPending,
  input logic             replayEvent,
  input logic             replayCntClr,
  input logic [CNT_W-1:0] timeoutLimit,
  input logic             timeoutPulse,
  input logic             rolloverPulse
);

  assert_timeout_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_rollover_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rolloverPulse |=> !rolloverPulse);

  assert_rollover_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    rolloverPulse |-> $past(replayEvent && !replayCntClr));

  assert_clear_blocks_roll_R9: assert property (@(posedge clk) disable iff (!rstN)
    replayCntClr |=> !rolloverPulse);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!unackPending && !txStart && !txEnd) |=> !timeoutPulse);

  assert_timeout_needs_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(unackPending));

endmodule

bind replay_watch replay_watch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .txStart       (txStart),
  .txEnd         (txEnd),
  .dllpRcvd      (dllpRcvd),
  .unackPending  (unackPending),
  .replayEvent   (replayEvent),
  .replayCntClr  (replayCntClr),
  .timeoutLimit  (timeoutLimit),
  .timeoutPulse  (timeoutPulse),
  .rolloverPulse (rolloverPulse)
);

// File: tb/tb_replay_watch.sv
`timescale 1ns/1ps
module tb_replay_watch;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             txStart = 1'b0;
  logic             txEnd = 1'b0;
  logic             dllpRcvd = 1'b0;
  logic             unackPending = 1'b0;
  logic             replayEvent = 1'b0;
  logic             replayCntClr = 1'b0;
  logic [CNT_W-1:0] timeoutLimit = '0;
  logic             timeoutPulse;
  logic             rolloverPulse;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  replay_watch #(.CNT_W(CNT_W)) dut (
    .clk           (clk),
    .rstN          (rstN),
    .txStart       (txStart),
    .txEnd         (txEnd),
    .dllpRcvd      (dllpRcvd),
    .unackPending  (unackPending),
    .replayEvent   (replayEvent),
    .replayCntClr  (replayCntClr),
    .timeoutLimit  (timeoutLimit),
    .timeoutPulse  (timeoutPulse),
    .rolloverPulse (rolloverPulse)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycles until timeoutPulse seen high, or -1 if not within maxN
  task automatic waitTimeout(input int maxN, output int n);
    int cnt = 0;
    bit seen = 0;
    while (!seen && cnt < maxN) begin
      tick();
      cnt++;
      if (timeoutPulse) seen = 1;
    end
    n = seen ? cnt : -1;
  endtask

  // Count timeout pulses over a window
  task automatic countTimeouts(input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      tick();
      if (timeoutPulse) n++;
    end
  endtask

  task automatic goIdle();
    unackPending = 1'b0;
    tick();
    tick();
  endtask

  task automatic startTimer(input bit useEnd);
    unackPending = 1'b1;
    if (useEnd) txEnd = 1'b1; else txStart = 1'b1;
    tick();
    txStart = 1'b0;
    txEnd   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int lim;
    int model;
    bit expRoll;
    bit prevRoll;

    // R1: reset state
    repeat (3) tick();
    check(!timeoutPulse && !rolloverPulse, "R1 outputs in reset", timeoutPulse + rolloverPulse, 0);
    rstN = 1'b1;
    timeoutLimit = 16'd4;
    unackPending = 1'b1;
    tick();
    check(!timeoutPulse && !rolloverPulse, "R1 outputs after reset", timeoutPulse + rolloverPulse, 0);
    countTimeouts(20, n);
    check(n == 0, "R1 idle timer no timeout", n, 0);
    // R1: replay count starts at zero: the fourth event rolls over
    for (int k = 1; k <= 4; k++) begin
      replayEvent = 1'b1;
      tick();
      replayEvent = 1'b0;
      check(rolloverPulse == (k == 4), "R1 replay count zero after reset", rolloverPulse, (k == 4));
    end
    goIdle();

    // R2, R5, R7: sweep limits, both start strobes
    for (int l = 0; l <= 6; l++) begin
      lim = (l == 0) ? 1 : l;
      timeoutLimit = CNT_W'(l);
      for (int s = 0; s < 2; s++) begin
        goIdle();
        startTimer(s[0]);
        waitTimeout(lim + 5, n);
        check(n == lim + 1, "R2 first timeout delay", n, lim + 1);
        tick();
        check(!timeoutPulse, "R7 timeout single cycle", timeoutPulse, 0);
        waitTimeout(lim + 5, n);
        check(n == lim, "R5 automatic restart period", n + 1, lim + 1);
      end
    end

    // R3: start strobe while running ignored
    for (int l = 2; l <= 6; l++) begin
      timeoutLimit = CNT_W'(l);
      for (int m = 0; m < l; m++) begin
        goIdle();
        startTimer(1'b0);
        repeat (m) tick();
        if (m[0]) txEnd = 1'b1; else txStart = 1'b1;
        tick();
        txStart = 1'b0;
        txEnd   = 1'b0;
        waitTimeout(l + 5, n);
        check(n == l - m, "R3 start while running ignored", n, l - m);
      end
    end

    // R4: received control packet restarts running timer
    for (int l = 2; l <= 6; l++) begin
      timeoutLimit = CNT_W'(l);
      for (int m = 0; m < l; m++) begin
        goIdle();
        startTimer(1'b1);
        repeat (m) tick();
        dllpRcvd = 1'b1;
        tick();
        dllpRcvd = 1'b0;
        waitTimeout(l + 5, n);
        check(n == l + 1, "R4 restart on DLLP", n, l + 1);
      end
    end
    // R4: DLLP while idle does not start
    timeoutLimit = 16'd3;
    goIdle();
    unackPending = 1'b1;
    dllpRcvd = 1'b1;
    tick();
    dllpRcvd = 1'b0;
    countTimeouts(15, n);
    check(n == 0, "R4 DLLP on idle timer", n, 0);

    // R6: dropping pending stops and clears
    for (int l = 1; l <= 5; l++) begin
      timeoutLimit = CNT_W'(l);
      for (int m = 0; m < l; m++) begin
        goIdle();
        startTimer(1'b0);
        repeat (m) tick();
        unackPending = 1'b0;
        countTimeouts(2 * l + 6, n);
        check(n == 0, "R6 stop when nothing pending", n, 0);
        unackPending = 1'b1;
        countTimeouts(2 * l + 6, n);
        check(n == 0, "R6 stays idle after clear", n, 0);
      end
    end
    goIdle();

    // R8, R9, R10: replay counter sweeps against an arithmetic model
    model = 0;
    prevRoll = 1'b0;
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 200; i++) begin
        replayEvent  = (p == 0) ? 1'b1 : ((((i >> (p - 1)) & 1) != 0) || (i % 5 == 0));
        replayCntClr = ((i % (17 + 6 * p)) == 16);
        expRoll = 1'b0;
        if (replayCntClr) model = 0;
        else if (replayEvent) begin
          if (model == 3) begin
            model = 0;
            expRoll = 1'b1;
          end else model = model + 1;
        end
        tick();
        if (replayCntClr)
          check(rolloverPulse == expRoll, "R9 clear priority", rolloverPulse, expRoll);
        else
          check(rolloverPulse == expRoll, "R8 rollover at three to four", rolloverPulse, expRoll);
        if (prevRoll)
          check(!rolloverPulse, "R10 rollover single cycle", rolloverPulse, 0);
        prevRoll = rolloverPulse;
      end
    end
    replayEvent  = 1'b0;
    replayCntClr = 1'b0;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule